// File: doc/BRIEF.md
# Daisy-Chain Codec Serial Port

This block is the digital serial interface of one codec in a chain of identical codecs. The chain starts at a host serial port and ends back at the host. Each device takes 16-bit frames on a data input marked by an input frame strobe. It sends frames out on a data output with its own frame strobe, and that output strobe drives the input strobe of the next device.

Each received frame falls into one of three kinds: a control frame (a register write or a readback request), a converter sample for the DAC, or a word that is only passing through. A control frame carries a relative address. A device that is not the target lowers the address by one and passes the frame on, so the frame reaches the device it names after the right number of hops. DAC samples move through the chain like a shift register. A device commits its DAC output only after it has seen as many DAC frames as its configured chain length. At each ADC sample event every device sends its own parallel ADC word. For a short relay window afterwards, a device passes upstream ADC words on untouched.

Top module: `cascade_serial_port`

## Requirements
- R1: After reset, sdo, sdo_fs and dac_update are 0 and dac_value is 0. Register 0 holds 8'h01, meaning a chain length of one, program mode and mixed mode off. Every other register holds 0.
- R2: A frame starts when sdi_fs is sampled high on a rising clock edge while no frame is being received. The next 16 rising edges sample sdi, MSB first. Any effect of the frame (register write, output frame start, DAC commit) appears at the edge after the 16th bit.
- R3: The kind of a frame depends on register 0. With bit 3 (mixed) set, bit 15 = 1 means control and bit 15 = 0 means DAC. With bit 3 clear and bit 4 clear (program mode), every frame is control. With bit 3 clear and bit 4 set (data mode), every frame is DAC.
- R4: A control frame has bit 14 for readback, bits 13:11 for the address, bits 10:8 for the register select and bits 7:0 for data. A frame whose address is 000 on arrival targets this device. A write stores the data in the selected register. A select of 4 or more changes nothing.
- R5: A control frame whose address is not 000 goes out again with the address lowered by one and all other bits unchanged. sdo_fs is high for one cycle after the edge that follows the last bit, and the 16 bits follow MSB first, one per cycle.
- R6: A readback that targets this device sends out the word {1, 1, 111, select, register contents}. An unimplemented select returns data 0.
- R7: Every DAC frame sends out the DAC word received before it, which is 0 after reset, and keeps the new word in its place.
- R8: DAC frames advance a counter. When the counter reaches the chain length (register 0 bits 2:0, where 0 means eight), dac_value takes the word just received, dac_update pulses for one cycle and the counter returns to 0. Control frames neither advance nor clear the counter, and dac_value changes only together with dac_update.
- R9: A high adc_strobe at a rising edge loads adc_word as an outgoing frame, with sdo_fs high in the following cycle. It takes priority over a frame-triggered output in the same cycle.
- R10: For chain-length × 24 cycles after an ADC strobe, received frames go out unchanged. They do not write registers and do not touch the DAC counter, the held DAC word or dac_value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdi | input | 1 | Serial data from host or upstream device |
| sdi_fs | input | 1 | Input frame strobe |
| adc_word | input | 16 | Parallel ADC sample |
| adc_strobe | input | 1 | ADC sample event, one cycle |
| sdo | output | 1 | Serial data toward the next device or host |
| sdo_fs | output | 1 | Output frame strobe |
| dac_value | output | 16 | Committed DAC word |
| dac_update | output | 1 | One-cycle pulse when dac_value is committed |
| ctrl_regs | output | 32 | Control registers, register n in bits 8n+7:8n |

## Verification
Control frames with nonzero addresses and mixed readback and data bits are driven through a table. This shows that only the address field is decremented and that, in program mode, bit 15 does not stop a frame being treated as control. Writes, an out-of-range select and a readback are sent at address zero. These separate a local write from a forwarded frame and pin down the cycle in which each takes effect. In mixed mode, two DAC samples are sent with a control frame between them. This shows that the DAC counter survives interleaved control traffic and that the held DAC word shifts out. In data mode, a frame with bit 15 set is committed as DAC data. A frame sent inside the post-ADC window comes out unchanged, while the same traffic after the window commits.

// File: rtl/cascport_pkg.sv
package cascport_pkg;
    // Frame handling decided for a completed received word
    typedef enum logic [1:0] {
        FR_CTRL  = 2'd0,
        FR_DAC   = 2'd1,
        FR_RELAY = 2'd2
    } frame_kind_e;

    localparam int HOP_CYCLES_DEFAULT = 24;
endpackage

// File: rtl/cascport_rx.sv
module cascport_rx #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sdi,
    input  logic         sdi_fs,
    output logic         done,
    output logic [W-1:0] word
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
        logic [W-1:0]  sr;
        logic          done;
        logic [W-1:0]  word;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d      = rx_q;
        rx_d.done = 1'b0;
        if (!rx_q.act) begin
            if (sdi_fs) begin
                rx_d.act = 1'b1;
                rx_d.cnt = '0;
            end
        end else begin
            rx_d.sr  = {rx_q.sr[W-2:0], sdi};
            rx_d.cnt = rx_q.cnt + 1'b1;
            if (rx_q.cnt == LAST) begin
                rx_d.act  = 1'b0;
                rx_d.done = 1'b1;
                rx_d.word = {rx_q.sr[W-2:0], sdi};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign done = rx_q.done;
    assign word = rx_q.word;
endmodule

// File: rtl/cascport_tx.sv
module cascport_tx #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    output logic         sdo,
    output logic         sdo_fs
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
        logic [W-1:0]  sr;
        logic          sdo;
        logic          fs;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d    = tx_q;
        tx_d.fs = 1'b0;
        if (load) begin
            tx_d.act = 1'b1;
            tx_d.cnt = '0;
            tx_d.sr  = load_word;
            tx_d.fs  = 1'b1;
            tx_d.sdo = 1'b0;
        end else if (tx_q.act) begin
            tx_d.sdo = tx_q.sr[W-1];
            tx_d.sr  = {tx_q.sr[W-2:0], 1'b0};
            tx_d.cnt = tx_q.cnt + 1'b1;
            if (tx_q.cnt == LAST) tx_d.act = 1'b0;
        end else begin
            tx_d.sdo = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign sdo    = tx_q.sdo;
    assign sdo_fs = tx_q.fs;
endmodule

// File: rtl/cascport_regfile.sv
module cascport_regfile #(
    parameter int          NREG  = 4,
    parameter int          DW    = 8,
    parameter int          SEL_W = 3,
    parameter logic [7:0]  RST0  = 8'h01
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [SEL_W-1:0]   sel,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    output logic [NREG*DW-1:0] regs_flat
);
    logic [DW-1:0] regs_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [DW-1:0] RVAL = (g == 0) ? DW'(RST0) : '0;
        logic [DW-1:0] r_d;

        always_comb begin
            r_d = regs_q[g];
            if (we && sel == SEL_W'(g)) r_d = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[g] <= RVAL;
            else        regs_q[g] <= r_d;
        end

        assign regs_flat[g*DW +: DW] = regs_q[g];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (sel == SEL_W'(i)) rdata = regs_q[i];
        end
    end
endmodule

// File: rtl/cascade_serial_port.sv
module cascade_serial_port
    import cascport_pkg::*;
#(
    parameter int W        = 16,
    parameter int ADDR_W   = 3,
    parameter int SEL_W    = 3,
    parameter int NREG     = 4,
    parameter int HOP      = HOP_CYCLES_DEFAULT
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                sdi,
    input  logic                                sdi_fs,
    input  logic [W-1:0]                        adc_word,
    input  logic                                adc_strobe,
    output logic                                sdo,
    output logic                                sdo_fs,
    output logic [W-1:0]                        dac_value,
    output logic                                dac_update,
    output logic [NREG*(W-2-ADDR_W-SEL_W)-1:0]  ctrl_regs
);
    // Field layout derived from the word width
    localparam int DW      = W - 2 - ADDR_W - SEL_W;
    localparam int SEL_LO  = DW;
    localparam int ADDR_LO = DW + SEL_W;
    localparam int RB_BIT  = W - 2;
    localparam int CT_BIT  = W - 1;
    localparam int MAXDEV  = 1 << ADDR_W;
    localparam int DEVN_W  = ADDR_W + 1;
    localparam int RLY_W   = $clog2(MAXDEV * HOP + 1);
    localparam int MIX_BIT = ADDR_W;
    localparam int DMD_BIT = ADDR_W + 1;

    typedef struct packed {
        logic [W-1:0]      hold;
        logic [DEVN_W-1:0] dcnt;
        logic [W-1:0]      dac;
        logic              upd;
        logic [RLY_W-1:0]  relay;
    } st_t;

    st_t st_d, st_q;

    logic              rx_done;
    logic [W-1:0]      rx_word;
    logic              tx_load;
    logic [W-1:0]      tx_word;
    logic              wr_en;
    logic [DW-1:0]     rd_data;
    logic [DW-1:0]     cfg;
    logic [DEVN_W-1:0] dev_n;
    frame_kind_e       kind;
    logic [ADDR_W-1:0] f_addr;
    logic [SEL_W-1:0]  f_sel;

    cascport_rx #(.W(W)) u_rx (
        .clk(clk), .rst_n(rst_n), .sdi(sdi), .sdi_fs(sdi_fs),
        .done(rx_done), .word(rx_word)
    );

    cascport_tx #(.W(W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .load_word(tx_word),
        .sdo(sdo), .sdo_fs(sdo_fs)
    );

    cascport_regfile #(.NREG(NREG), .DW(DW), .SEL_W(SEL_W), .RST0(8'h01)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .sel(f_sel),
        .wdata(rx_word[DW-1:0]), .rdata(rd_data), .regs_flat(ctrl_regs)
    );

    assign cfg    = ctrl_regs[DW-1:0];
    assign dev_n  = (cfg[ADDR_W-1:0] == '0) ? DEVN_W'(MAXDEV) : {1'b0, cfg[ADDR_W-1:0]};
    assign f_addr = rx_word[ADDR_LO +: ADDR_W];
    assign f_sel  = rx_word[SEL_LO +: SEL_W];

    // Frame classification
    always_comb begin
        if (st_q.relay != '0)  kind = FR_RELAY;
        else if (cfg[MIX_BIT]) kind = rx_word[CT_BIT] ? FR_CTRL : FR_DAC;
        else                   kind = cfg[DMD_BIT] ? FR_DAC : FR_CTRL;
    end

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        wr_en    = 1'b0;
        tx_load  = 1'b0;
        tx_word  = '0;
        if (st_q.relay != '0) st_d.relay = st_q.relay - 1'b1;

        if (rx_done) begin
            unique case (kind)
                FR_RELAY: begin
                    tx_load = 1'b1;
                    tx_word = rx_word;
                end
                FR_CTRL: begin
                    if (f_addr != '0) begin
                        tx_load = 1'b1;
                        tx_word = rx_word;
                        tx_word[ADDR_LO +: ADDR_W] = f_addr - 1'b1;
                    end else if (rx_word[RB_BIT]) begin
                        tx_load = 1'b1;
                        tx_word = {1'b1, 1'b1, {ADDR_W{1'b1}}, f_sel, rd_data};
                    end else begin
                        wr_en = 1'b1;
                    end
                end
                FR_DAC: begin
                    tx_load   = 1'b1;
                    tx_word   = st_q.hold;
                    st_d.hold = rx_word;
                    if (st_q.dcnt + 1'b1 == dev_n) begin
                        st_d.dac  = rx_word;
                        st_d.upd  = 1'b1;
                        st_d.dcnt = '0;
                    end else begin
                        st_d.dcnt = st_q.dcnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end

        // ADC sample event wins the serializer and opens the relay window
        if (adc_strobe) begin
            tx_load    = 1'b1;
            tx_word    = adc_word;
            st_d.relay = RLY_W'(int'(dev_n) * HOP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dac_value  = st_q.dac;
    assign dac_update = st_q.upd;
endmodule

// File: rtl/cascport_checker.sv
module cascport_checker #(
    parameter int W     = 16,
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             adc_strobe,
    input logic             rx_done,
    input logic             sdo_fs,
    input logic             dac_update,
    input logic [W-1:0]     dac_value,
    input logic [REG_W-1:0] ctrl_regs
);
    // R9: an ADC event starts an output frame in the next cycle
    assert_adc_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        adc_strobe |=> sdo_fs);

    // R5: an output frame only follows a completed input frame or an ADC event
    assert_fs_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_fs |-> ($past(rx_done) || $past(adc_strobe)));

    // R8: the commit strobe is a single-cycle pulse
    assert_upd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dac_update |=> !dac_update);

    // R8: a commit follows a completed input frame
    assert_upd_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dac_update |-> $past(rx_done));

    // R8: the DAC output moves only with its strobe
    assert_dac_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_value) |-> dac_update);

    // R4: registers change only right after a completed input frame
    assert_regs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_regs) |-> $past(rx_done));
endmodule

bind cascade_serial_port cascport_checker #(.W(W), .REG_W(NREG*DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .adc_strobe(adc_strobe), .rx_done(rx_done),
    .sdo_fs(sdo_fs), .dac_update(dac_update), .dac_value(dac_value),
    .ctrl_regs(ctrl_regs)
);

// File: tb/tb_cascade_serial_port.sv
`timescale 1ns/1ps
module tb_cascade_serial_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdi = 1'b0;
    logic        sdi_fs = 1'b0;
    logic [15:0] adc_word = '0;
    logic        adc_strobe = 1'b0;
    logic        sdo, sdo_fs, dac_update;
    logic [15:0] dac_value;
    logic [31:0] ctrl_regs;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    cascade_serial_port dut (
        .clk(clk), .rst_n(rst_n), .sdi(sdi), .sdi_fs(sdi_fs),
        .adc_word(adc_word), .adc_strobe(adc_strobe),
        .sdo(sdo), .sdo_fs(sdo_fs), .dac_value(dac_value),
        .dac_update(dac_update), .ctrl_regs(ctrl_regs)
    );

    // Output frame capture
    logic [15:0] cap [64];
    int          cap_n = 0;
    int          exp_idx = 0;
    logic        cap_on = 1'b0;
    int          cap_bits = 0;
    logic [15:0] cap_sr = '0;
    int          upd_n = 0;
    logic [15:0] upd_last = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            cap_on <= 1'b0;
        end else if (cap_on) begin
            if (cap_bits == 15) begin
                cap[cap_n % 64] <= {cap_sr[14:0], sdo};
                cap_n  <= cap_n + 1;
                cap_on <= 1'b0;
            end
            cap_sr   <= {cap_sr[14:0], sdo};
            cap_bits <= cap_bits + 1;
        end else if (sdo_fs) begin
            cap_on   <= 1'b1;
            cap_bits <= 0;
        end
        if (rst_n && dac_update) begin
            upd_n    <= upd_n + 1;
            upd_last <= dac_value;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [15:0] w);
        @(negedge clk); sdi_fs = 1'b1;
        for (int i = 15; i >= 0; i--) begin
            @(negedge clk); sdi_fs = 1'b0; sdi = w[i];
        end
    endtask

    task automatic settle();
        repeat (20) @(negedge clk);
        sdi = 1'b0;
    endtask

    task automatic expect_frame(input logic [15:0] w, input string req);
        if (cap_n > exp_idx) check(cap[exp_idx % 64] == w, req, 32'(cap[exp_idx % 64]), 32'(w));
        else                 check(1'b0, req, 32'hFFFF_FFFF, 32'(w));
        exp_idx++;
    endtask

    task automatic expect_no_frame(input string req);
        check(cap_n == exp_idx, req, 32'(cap_n), 32'(exp_idx));
        exp_idx = cap_n;
    endtask

    // Forwarding vectors in program mode: {sent, expected out}
    localparam logic [31:0] FWD_VEC [5] = '{
        {16'h8A5A, 16'h825A},
        {16'hFBFF, 16'hF3FF},
        {16'hA000, 16'h9800},
        {16'h0A5A, 16'h025A},
        {16'h973C, 16'h8F3C}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sdo == 1'b0 && sdo_fs == 1'b0, "R1 serial out idle", {30'b0, sdo, sdo_fs}, 32'h0);
        check(dac_update == 1'b0 && dac_value == 16'h0, "R1 dac idle", 32'(dac_value), 32'h0);
        check(ctrl_regs == 32'h0000_0001, "R1 register reset", ctrl_regs, 32'h1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5/R3: table of forwarded control frames in program mode
        foreach (FWD_VEC[i]) begin
            send(FWD_VEC[i][31:16]);
            settle();
            expect_frame(FWD_VEC[i][15:0], "R5 forwarded address minus one");
            check(ctrl_regs == 32'h0000_0001, "R4 non-addressed leaves registers", ctrl_regs, 32'h1);
        end

        // R2/R4: write register 1, effect at the edge after the last bit
        send(16'h81A5);
        @(negedge clk);
        check(ctrl_regs[15:8] == 8'h00, "R2 write not before commit edge", 32'(ctrl_regs[15:8]), 32'h0);
        @(negedge clk);
        check(ctrl_regs[15:8] == 8'hA5, "R2 write at commit edge", 32'(ctrl_regs[15:8]), 32'hA5);
        settle();
        expect_no_frame("R4 local write sends nothing");

        // R4: out-of-range select ignored
        send(16'h8577);
        settle();
        check(ctrl_regs == 32'h0000_A501, "R4 select beyond register count", ctrl_regs, 32'h0000_A501);

        // R6: readback of register 1
        send(16'hC100);
        @(negedge clk);
        check(sdo_fs == 1'b0, "R5 no strobe before load edge", 32'(sdo_fs), 32'h0);
        @(negedge clk);
        check(sdo_fs == 1'b1, "R5 strobe after load edge", 32'(sdo_fs), 32'h1);
        settle();
        expect_frame(16'hF9A5, "R6 readback word");

        // R3: mixed mode, chain length two
        send(16'h800A);
        settle();
        check(ctrl_regs == 32'h0000_A50A, "R3 config write", ctrl_regs, 32'h0000_A50A);

        // R7/R8: DAC frames with a control frame between them
        send(16'h1234);
        settle();
        expect_frame(16'h0000, "R7 first DAC frame sends reset hold");
        check(upd_n == 0, "R8 no commit before count", 32'(upd_n), 32'h0);
        send(16'h8A5A);
        settle();
        expect_frame(16'h825A, "R3 mixed MSB one is control");
        send(16'h0ABC);
        settle();
        expect_frame(16'h1234, "R7 held DAC word shifted out");
        check(upd_n == 1 && upd_last == 16'h0ABC, "R8 commit at count two", {upd_n[15:0], upd_last}, {16'h1, 16'h0ABC});
        check(dac_value == 16'h0ABC, "R8 dac value", 32'(dac_value), 32'h0ABC);

        // R3: data mode, chain length one, MSB one is still DAC
        send(16'h8011);
        settle();
        expect_no_frame("R4 config write sends nothing");
        send(16'h8F00);
        settle();
        expect_frame(16'h0ABC, "R3 data mode forwards hold");
        check(upd_n == 2 && dac_value == 16'h8F00, "R3 data mode commits MSB one word", 32'(dac_value), 32'h8F00);

        // R9/R10: ADC event then a relayed frame inside the window
        @(negedge clk); adc_word = 16'hBEEF; adc_strobe = 1'b1;
        @(negedge clk); adc_strobe = 1'b0;
        check(sdo_fs == 1'b1, "R9 strobe after ADC event", 32'(sdo_fs), 32'h1);
        send(16'h4444);
        settle();
        expect_frame(16'hBEEF, "R9 ADC word");
        expect_frame(16'h4444, "R10 relayed unchanged");
        check(upd_n == 2 && dac_value == 16'h8F00, "R10 relay leaves DAC", 32'(dac_value), 32'h8F00);

        // After the window the same traffic commits again
        repeat (30) @(negedge clk);
        send(16'h5555);
        settle();
        expect_frame(16'h8F00, "R10 hold untouched by relay");
        check(upd_n == 3 && dac_value == 16'h5555, "R8 commit after window", 32'(dac_value), 32'h5555);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule